// File: doc/BRIEF.md
# Indexed Multi-Socket Register Port

This block is a compact host-facing register window. The host sees only two byte addresses. One is an index port, selected by `host_sel` = 0. The other is a data port, selected by `host_sel` = 1. The host writes an index byte first. Later reads and writes on the data port then reach the 8-bit control register that the index selects. The top two index bits pick one of up to four sockets, and the lower six bits pick one of the 64 registers in that socket's bank.

The block holds all bank storage. It exposes every stored byte to neighbouring logic as a flat image, and it drives each socket's memory-page byte as a separate output. Each socket also has one read-only status index whose value comes from outside the block. Reads are signalled back to the owning logic through a one-cycle pulse for each index, so that logic can apply read side effects. A configuration input limits how many sockets answer. Banks beyond that limit read as 0xFF and ignore writes. Values wider than a byte are kept in consecutive indices.

Top module: `idx_sock_regport`

## Requirements
- R1: A write with `host_sel`=0 loads `host_wdata` into the index register. The index register resets to 0x00. A read with `host_sel`=0 returns the current index.
- R2: A write with `host_sel`=1 stores the byte in the register selected by the index, where index bits 7:6 give the socket and bits 5:0 give the offset. The byte then appears on `reg_image[((sock*64)+off)*8 +: 8]`.
- R3: A read strobe makes `host_rdata` carry the selected value, with `host_rvalid` high for exactly one cycle, on the cycle after the strobe.
- R4: The index never changes by itself. Data accesses that follow reuse the last index written, so a read-modify-write is done as an index write, a data read, an index write and a data write, and it affects only that register.
- R5: A 16-bit value is held low byte first, at offset n, with its high byte at offset n+1. Both bytes are reached through ordinary byte accesses.
- R6: The number of active sockets follows `cfg_mode`: 2'b00 gives 2 sockets, 2'b01 gives 1 socket, and 2'b1x gives 4 sockets.
- R7: A data read from a socket at or above the active count returns 0xFF. A data write to such a socket changes no stored byte.
- R8: Offset 0x01 of each bank is read-only. Reading it returns that socket's `sock_stat` byte, and writing it leaves stored state unchanged.
- R9: Offset 0x26 of each bank is the memory-page register. Its stored byte drives `win_page[sock*8 +: 8]`, which supplies address bits 31:24.
- R10: A data read of an active socket pulses `rd_pulse[sock*64+off]` for one cycle, in the same cycle that `host_rvalid` is high. An index-port read or a disabled-socket read leaves `rd_pulse` at zero.
- R11: Every stored register resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Selects the active socket count |
| host_sel | input | 1 | 0 = index port, 1 = data port |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read data valid |
| sock_stat | input | SOCK_MAX*8 | Status byte of each socket, read at offset 0x01 |
| reg_image | output | SOCK_MAX*BANK_REGS*8 | All stored register bytes |
| win_page | output | SOCK_MAX*8 | Memory-page byte of each socket |
| rd_pulse | output | SOCK_MAX*BANK_REGS | Read pulse for each index |

## Verification
The bench builds the block with its default parameters: four socket banks of 64 registers each. With these values all three socket-count encodings can be reached, so the same stored byte can be seen from a socket while it is enabled, while it is disabled, and again after it is re-enabled. The full 8-bit index is also used. This lets the bench show that offset 5 of sockets 0 and 1 are separate registers, and that writes to socket 3's image land at the top bit positions.

// File: rtl/regport_pkg.sv
package regport_pkg;
    localparam int unsigned BYTE_W = 8;

    // Active socket count from the two configuration bits
    function automatic logic [2:0] cfg_to_count(input logic [1:0] mode);
        if (mode[1])
            return 3'd4;
        else if (mode[0])
            return 3'd1;
        else
            return 3'd2;
    endfunction
endpackage

// File: rtl/regport_idx_dec.sv
module regport_idx_dec #(
    parameter int unsigned SOCK_W = 2,
    parameter int unsigned OFF_W  = 6
) (
    input  logic [7:0]        idx,
    input  logic [1:0]        cfg_mode,
    output logic [SOCK_W-1:0] sock,
    output logic [OFF_W-1:0]  off,
    output logic              hit
);
    import regport_pkg::*;

    logic [2:0] active_cnt;

    always_comb begin
        sock       = idx[OFF_W +: SOCK_W];
        off        = idx[OFF_W-1:0];
        active_cnt = cfg_to_count(cfg_mode);
        hit        = int'(sock) < int'(active_cnt);
    end
endmodule

// File: rtl/regport_bank.sv
module regport_bank #(
    parameter int unsigned BANK_REGS = 64,
    parameter int unsigned OFF_W     = 6,
    parameter int unsigned STAT_OFF  = 1,
    parameter int unsigned PAGE_OFF  = 38
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [OFF_W-1:0]       off,
    input  logic [7:0]             wdata,
    input  logic [7:0]             stat_i,
    output logic [7:0]             rdata_o,
    output logic [BANK_REGS*8-1:0] image_o,
    output logic [7:0]             page_o,
    output logic [BANK_REGS-1:0]   pulse_o
);
    typedef struct packed {
        logic [BANK_REGS-1:0][7:0] regs;
        logic [BANK_REGS-1:0]      pulse;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     is_stat;

    always_comb begin
        is_stat = (off == OFF_W'(STAT_OFF));
        st_d = st_q;
        st_d.pulse = '0;
        if (wr_en && !is_stat)
            st_d.regs[off] = wdata;
        if (rd_en)
            st_d.pulse[off] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rdata_o = is_stat ? stat_i : st_q.regs[off];
    assign image_o = st_q.regs;
    assign page_o  = st_q.regs[PAGE_OFF];
    assign pulse_o = st_q.pulse;

    // R8
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_stat) |=> $stable(image_o));

    // R10
    rd_pulse_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (pulse_o[$past(off)] && $onehot0(pulse_o)));
endmodule

// File: rtl/idx_sock_regport.sv
module idx_sock_regport #(
    parameter int unsigned SOCK_MAX  = 4,
    parameter int unsigned BANK_REGS = 64,
    parameter int unsigned STAT_OFF  = 1,
    parameter int unsigned PAGE_OFF  = 38
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [1:0]                      cfg_mode,
    input  logic                            host_sel,
    input  logic                            host_wr,
    input  logic                            host_rd,
    input  logic [7:0]                      host_wdata,
    output logic [7:0]                      host_rdata,
    output logic                            host_rvalid,
    input  logic [SOCK_MAX*8-1:0]           sock_stat,
    output logic [SOCK_MAX*BANK_REGS*8-1:0] reg_image,
    output logic [SOCK_MAX*8-1:0]           win_page,
    output logic [SOCK_MAX*BANK_REGS-1:0]   rd_pulse
);
    localparam int unsigned SOCK_W = $clog2(SOCK_MAX);
    localparam int unsigned OFF_W  = $clog2(BANK_REGS);

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] rdata;
        logic       rvalid;
    } port_st_t;

    port_st_t          st_d, st_q;
    logic [SOCK_W-1:0] sel_sock;
    logic [OFF_W-1:0]  sel_off;
    logic              sel_hit;
    logic [7:0]        bank_rd [SOCK_MAX];

    regport_idx_dec #(.SOCK_W(SOCK_W), .OFF_W(OFF_W)) u_dec (
        .idx      (st_q.index),
        .cfg_mode (cfg_mode),
        .sock     (sel_sock),
        .off      (sel_off),
        .hit      (sel_hit)
    );

    for (genvar g = 0; g < SOCK_MAX; g++) begin : g_bank
        logic mine;
        assign mine = sel_hit && (sel_sock == SOCK_W'(g));
        regport_bank #(
            .BANK_REGS (BANK_REGS),
            .OFF_W     (OFF_W),
            .STAT_OFF  (STAT_OFF),
            .PAGE_OFF  (PAGE_OFF)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (host_wr && host_sel && mine),
            .rd_en   (host_rd && host_sel && mine),
            .off     (sel_off),
            .wdata   (host_wdata),
            .stat_i  (sock_stat[g*8 +: 8]),
            .rdata_o (bank_rd[g]),
            .image_o (reg_image[g*BANK_REGS*8 +: BANK_REGS*8]),
            .page_o  (win_page[g*8 +: 8]),
            .pulse_o (rd_pulse[g*BANK_REGS +: BANK_REGS])
        );
    end

    always_comb begin
        st_d = st_q;
        st_d.rvalid = host_rd;
        if (host_wr && !host_sel)
            st_d.index = host_wdata;
        if (host_rd) begin
            if (!host_sel)
                st_d.rdata = st_q.index;
            else if (sel_hit)
                st_d.rdata = bank_rd[sel_sock];
            else
                st_d.rdata = 8'hFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;

    // R3
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);

    // R3
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);

    // R4
    index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !host_sel) |=> $stable(st_q.index));

    // R7
    off_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel && !sel_hit) |=> (host_rdata == 8'hFF && rd_pulse == '0));

    // R7
    off_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && !sel_hit) |=> $stable(reg_image));

    // R10
    idx_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_sel) |=> (rd_pulse == '0));
endmodule

// File: tb/idx_sock_regport_test.sv
`timescale 1ns/1ps
module idx_sock_regport_test;
    localparam int NS = 4;
    localparam int NR = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_mode = 2'b10;
    logic              host_sel = 1'b0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [7:0]        host_wdata = '0;
    logic [7:0]        host_rdata;
    logic              host_rvalid;
    logic [NS*8-1:0]   sock_stat = '0;
    logic [NS*NR*8-1:0] reg_image;
    logic [NS*8-1:0]   win_page;
    logic [NS*NR-1:0]  rd_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] data;
        int         pidx;
        string      tag;
    } exp_t;
    exp_t sb[$];

    idx_sock_regport uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .host_sel(host_sel),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .sock_stat(sock_stat),
        .reg_image(reg_image), .win_page(win_page), .rd_pulse(rd_pulse)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic get(input logic sel, input logic [7:0] exp, input int pidx, input string tag);
        exp_t e;
        @(negedge clk);
        e.data = exp; e.pidx = pidx; e.tag = tag;
        sb.push_back(e);
        host_sel = sel; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic [7:0] img(input int s, input int o);
        return reg_image[(s*NR+o)*8 +: 8];
    endfunction

    // Monitor: compare each read result as it appears
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R3: actual unexpected rvalid expected none");
            end else begin
                exp_t e;
                logic [NS*NR-1:0] ep;
                e = sb.pop_front();
                ep = '0;
                if (e.pidx >= 0) ep[e.pidx] = 1'b1;
                chk({e.tag, " data"}, {24'd0, host_rdata}, {24'd0, e.data});
                n_cmp++;
                if (rd_pulse !== ep) begin
                    n_bad++;
                    $display("FAIL R10 %s pulse: actual %h expected %h", e.tag, rd_pulse, ep);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 / R1 reset state
        chk("R11 image zero", {31'd0, (reg_image == '0)}, 32'd1);
        chk("R9 page reset", {24'd0, win_page[7:0]}, 32'd0);
        get(1'b0, 8'h00, -1, "R1 reset index");
        get(1'b1, 8'h00, 0, "R11 reg0 reset");

        // R2 / R3 basic write and read back
        put(1'b0, 8'h05);
        put(1'b1, 8'hA5);
        chk("R2 image s0 o5", {24'd0, img(0, 5)}, 32'hA5);
        get(1'b1, 8'hA5, 5, "R3 read s0 o5");
        put(1'b0, 8'hC7);
        put(1'b1, 8'h3C);
        chk("R2 image s3 o7", {24'd0, img(3, 7)}, 32'h3C);
        get(1'b0, 8'hC7, -1, "R1 index readback");

        // R4 read-modify-write on socket 1 offset 5
        put(1'b0, 8'h45);
        get(1'b1, 8'h00, NR + 5, "R4 rmw read");
        put(1'b0, 8'h45);
        put(1'b1, 8'h5A);
        get(1'b1, 8'h5A, NR + 5, "R4 index persists");
        chk("R4 other socket untouched", {24'd0, img(0, 5)}, 32'hA5);

        // R5 16-bit value in two consecutive indices
        put(1'b0, 8'h90);
        put(1'b1, 8'h34);
        put(1'b0, 8'h91);
        put(1'b1, 8'h12);
        chk("R5 16-bit image", {16'd0, reg_image[(2*NR+16)*8 +: 16]}, 32'h1234);

        // R8 read-only status offset
        sock_stat[2*8 +: 8] = 8'h9E;
        put(1'b0, 8'h81);
        get(1'b1, 8'h9E, 2*NR + 1, "R8 status read");
        put(1'b1, 8'h00);
        get(1'b1, 8'h9E, 2*NR + 1, "R8 status after write");
        chk("R8 stored unchanged", {24'd0, img(2, 1)}, 32'h00);

        // R9 page register
        put(1'b0, 8'h66);
        put(1'b1, 8'h7F);
        chk("R9 page s1", {24'd0, win_page[8 +: 8]}, 32'h7F);
        chk("R9 page s0 idle", {24'd0, win_page[0 +: 8]}, 32'h00);

        // R6 / R7 two sockets: socket 2 disabled
        cfg_mode = 2'b00;
        put(1'b0, 8'h85);
        put(1'b1, 8'h11);
        chk("R7 write ignored", {24'd0, img(2, 5)}, 32'h00);
        get(1'b1, 8'hFF, -1, "R7 disabled read");
        put(1'b0, 8'h45);
        get(1'b1, 8'h5A, NR + 5, "R6 two sockets s1 on");

        // R6 one socket
        cfg_mode = 2'b01;
        get(1'b1, 8'hFF, -1, "R6 one socket s1 off");
        put(1'b0, 8'h05);
        get(1'b1, 8'hA5, 5, "R6 one socket s0 on");

        // R6 four sockets via 2'b11
        cfg_mode = 2'b11;
        put(1'b0, 8'h85);
        get(1'b1, 8'h00, 2*NR + 5, "R7 re-enabled unchanged");
        put(1'b0, 8'hC7);
        get(1'b1, 8'h3C, 3*NR + 7, "R6 four sockets s3");

        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", sb.size(), 32'd0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule